// File: doc/BRIEF.md
# Interrupt Vector Address Generator

This block turns the vector number of an interrupt that has already been taken into the start address of its handler, and picks the shadow register set the handler runs with. It does no arbitration and fetches nothing. The arbiter presents a request strobe with a vector number and a priority. One clock later the block returns the handler address, the register-set number and a one-cycle valid pulse.

Two address schemes are supported, chosen by a static mode input. In spaced mode the address is the base plus the vector number times a programmable stride, plus a fixed offset of 0x200. Spaced mode covers 64 vectors. In table mode each of 191 vectors has a writable 18-bit offset, which is added to the base. This keeps every handler within 256 KiB above the base.

The two modes also pick the register set differently. In table mode a map holds one 4-bit set number per priority level. In spaced mode there is a single shadow set, numbered 1, and only one configured priority uses it. A small register port writes the base, the stride code, the table entries, the priority map and the shadow priority. Its read data always shows the addressed register's contents before the write, so a write also returns the old value in the same cycle.

Top module: `irq_vector_gen`

## Requirements
- R1: After reset `out_valid` is 0. The base (config address 0x100) reads 0x9D000000. The stride code (0x101, bits 2:0) reads 3. The priority map (0x102) reads 0x76543210. The shadow priority (0x103, bits 2:0) reads 7. Every table entry (config addresses 0 to 190, bits 17:0) reads 0.
- R2: In spaced mode (`mode_tbl`=0), a vector below 64 gives `out_addr` = base + stride × vector + 0x200. Stride code c selects 4·2^c bytes for c from 1 to 7, which gives 8 up to 512 bytes.
- R3: Stride code 0 selects a stride of 0, so every in-range vector maps to base + 0x200.
- R4: In table mode (`mode_tbl`=1), a vector below 191 gives `out_addr` = base + the entry's offset. Only bits 17:0 of a written entry are kept.
- R5: A vector of 64 or more in spaced mode, or of 191 or more in table mode, sets `out_err`=1 and gives `out_addr` = base. In-range vectors give `out_err`=0.
- R6: In table mode, `out_set` is the 4-bit map field at bits 4p+3:4p, where p is the request priority.
- R7: In spaced mode, `out_set` is 1 when the request priority equals the shadow priority, and 0 otherwise.
- R8: While `cfg_we` is high, `cfg_rdata` shows the addressed register's contents from before the write. The new value applies from the next clock edge. Unmapped addresses read 0.
- R9: The outputs appear exactly one cycle after `req` is sampled, with `out_valid` high for that one cycle per request. Back-to-back requests give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_tbl | input | 1 | 0 = spaced mode, 1 = table mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Contents of the addressed register (value from before the write) |
| req | input | 1 | Taken-interrupt strobe |
| req_vec | input | 8 | Vector number |
| req_prio | input | 3 | Priority of the taken interrupt |
| out_valid | output | 1 | Result valid pulse |
| out_addr | output | 32 | Handler start address |
| out_set | output | 4 | Shadow register set number |
| out_err | output | 1 | Vector out of range for the active mode |

## Verification
The bench builds the block with its default parameters: 64 spaced vectors, 191 table entries, an 8-bit vector and 18-bit offsets. With these values both range edges can be tested directly. Vectors 63 and 64 sit on the spaced-mode edge, and 190 and 191 on the table-mode edge. Vector 255 can also be driven, which lies beyond both. The 18-bit offset width lets a write of a 19-bit value show the truncation. The full set of stride codes, from the zero stride up to 512 bytes, stays within the 32-bit address.

// File: rtl/ivag_pkg.sv
package ivag_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CFG_AW = 9;
  localparam int unsigned CODE_W = 3;

  localparam logic [CFG_AW-1:0] CFG_BASE  = 9'h100;
  localparam logic [CFG_AW-1:0] CFG_SPACE = 9'h101;
  localparam logic [CFG_AW-1:0] CFG_SMAP  = 9'h102;
  localparam logic [CFG_AW-1:0] CFG_SPRIO = 9'h103;

  typedef enum logic {MODE_SPACED = 1'b0, MODE_TABLE = 1'b1} vec_mode_e;
endpackage

// File: rtl/ivag_cfg_regs.sv
module ivag_cfg_regs
  import ivag_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFF_W    = 18,
  parameter int unsigned NUM_TBL  = 191,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned SET_W    = 4,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'h9D00_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [DATA_W-1:0]            cfg_rdata,
  input  logic [VEC_W-1:0]             lk_idx,
  output logic [OFF_W-1:0]             lk_off,
  output logic [ADDR_W-1:0]            base_o,
  output logic [CODE_W-1:0]            code_o,
  output logic [(2**PRIO_W)*SET_W-1:0] map_o,
  output logic [PRIO_W-1:0]            sprio_o
);
  localparam int unsigned NUM_PRIO = 2 ** PRIO_W;
  localparam int unsigned MAP_W    = NUM_PRIO * SET_W;
  localparam logic [CFG_AW-1:0] TBL_END = CFG_AW'(NUM_TBL);
  localparam logic [VEC_W:0]    LK_END  = (VEC_W+1)'(NUM_TBL);

  function automatic logic [MAP_W-1:0] ident_map();
    logic [MAP_W-1:0] r;
    r = '0;
    for (int p = 0; p < NUM_PRIO; p++) r[p*SET_W +: SET_W] = SET_W'(p);
    return r;
  endfunction

  logic [ADDR_W-1:0] base_q, base_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [MAP_W-1:0]  map_q, map_d;
  logic [PRIO_W-1:0] sprio_q, sprio_d;
  logic [OFF_W-1:0]  tbl_q [NUM_TBL];
  logic [NUM_TBL-1:0] tbl_we;
  logic              hit_tbl;

  assign hit_tbl = cfg_addr < TBL_END;

  always_comb begin
    base_d  = base_q;
    code_d  = code_q;
    map_d   = map_q;
    sprio_d = sprio_q;
    if (cfg_we) begin
      case (cfg_addr)
        CFG_BASE:  base_d  = cfg_wdata[ADDR_W-1:0];
        CFG_SPACE: code_d  = cfg_wdata[CODE_W-1:0];
        CFG_SMAP:  map_d   = cfg_wdata[MAP_W-1:0];
        CFG_SPRIO: sprio_d = cfg_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= BASE_RST;
      code_q  <= CODE_W'(3);
      map_q   <= ident_map();
      sprio_q <= PRIO_W'(NUM_PRIO - 1);
    end else begin
      base_q  <= base_d;
      code_q  <= code_d;
      map_q   <= map_d;
      sprio_q <= sprio_d;
    end
  end

  for (genvar i = 0; i < NUM_TBL; i++) begin : g_entry
    assign tbl_we[i] = cfg_we && hit_tbl && (cfg_addr == CFG_AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tbl_q[i] <= '0;
      else if (tbl_we[i]) tbl_q[i] <= cfg_wdata[OFF_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit_tbl) cfg_rdata = DATA_W'(tbl_q[cfg_addr[VEC_W-1:0]]);
    else begin
      case (cfg_addr)
        CFG_BASE:  cfg_rdata = DATA_W'(base_q);
        CFG_SPACE: cfg_rdata = DATA_W'(code_q);
        CFG_SMAP:  cfg_rdata = DATA_W'(map_q);
        CFG_SPRIO: cfg_rdata = DATA_W'(sprio_q);
        default:   cfg_rdata = '0;
      endcase
    end
  end

  assign lk_off  = ({1'b0, lk_idx} < LK_END) ? tbl_q[lk_idx] : '0;
  assign base_o  = base_q;
  assign code_o  = code_q;
  assign map_o   = map_q;
  assign sprio_o = sprio_q;

  // R8: a write to the base is visible on the next cycle
  assert_base_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_BASE) |=> base_o == $past(cfg_wdata[ADDR_W-1:0]));
endmodule

// File: rtl/ivag_addr_calc.sv
module ivag_addr_calc
  import ivag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFF_W      = 18,
  parameter int unsigned NUM_SPACED = 64,
  parameter int unsigned NUM_TBL    = 191,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned FIXED_OFF  = 32'h200
) (
  input  vec_mode_e          mode,
  input  logic [VEC_W-1:0]   vec,
  input  logic [ADDR_W-1:0]  base,
  input  logic [CODE_W-1:0]  code,
  input  logic [OFF_W-1:0]   off,
  output logic [ADDR_W-1:0]  addr,
  output logic               err
);
  localparam logic [VEC_W:0] SP_END  = (VEC_W+1)'(NUM_SPACED);
  localparam logic [VEC_W:0] TBL_END = (VEC_W+1)'(NUM_TBL);

  logic [CODE_W:0]   shamt;
  logic [ADDR_W-1:0] stride_prod, spaced_addr, table_addr;
  logic              in_range;

  always_comb begin
    shamt       = {1'b0, code} + (CODE_W+1)'(2);
    stride_prod = (code == '0) ? '0 : (ADDR_W'(vec) << shamt);
    spaced_addr = base + stride_prod + ADDR_W'(FIXED_OFF);
    table_addr  = base + ADDR_W'(off);
    in_range    = (mode == MODE_TABLE) ? ({1'b0, vec} < TBL_END)
                                       : ({1'b0, vec} < SP_END);
    err         = !in_range;
    if (!in_range)                addr = base;
    else if (mode == MODE_TABLE)  addr = table_addr;
    else                          addr = spaced_addr;
  end
endmodule

// File: rtl/ivag_set_sel.sv
module ivag_set_sel
  import ivag_pkg::*;
#(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned SET_W  = 4
) (
  input  vec_mode_e                    mode,
  input  logic [PRIO_W-1:0]            prio,
  input  logic [(2**PRIO_W)*SET_W-1:0] map,
  input  logic [PRIO_W-1:0]            sprio,
  output logic [SET_W-1:0]             set
);
  always_comb begin
    if (mode == MODE_TABLE) set = map[int'(prio)*SET_W +: SET_W];
    else if (prio == sprio) set = SET_W'(1);
    else                    set = '0;
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import ivag_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned OFF_W      = 18,
  parameter int unsigned NUM_SPACED = 64,
  parameter int unsigned NUM_TBL    = 191,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned PRIO_W     = 3,
  parameter int unsigned SET_W      = 4,
  parameter int unsigned FIXED_OFF  = 32'h200,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'h9D00_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tbl,
  input  logic              cfg_we,
  input  logic [8:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SET_W-1:0]  out_set,
  output logic              out_err
);
  localparam int unsigned MAP_W = (2 ** PRIO_W) * SET_W;

  vec_mode_e         mode;
  logic [OFF_W-1:0]  lk_off;
  logic [ADDR_W-1:0] base_w, calc_addr;
  logic [CODE_W-1:0] code_w;
  logic [MAP_W-1:0]  map_w;
  logic [PRIO_W-1:0] sprio_w;
  logic [SET_W-1:0]  calc_set;
  logic              calc_err;

  assign mode = vec_mode_e'(mode_tbl);

  ivag_cfg_regs #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_TBL(NUM_TBL), .VEC_W(VEC_W),
    .PRIO_W(PRIO_W), .SET_W(SET_W), .BASE_RST(BASE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_idx(req_vec),
    .lk_off(lk_off), .base_o(base_w), .code_o(code_w), .map_o(map_w),
    .sprio_o(sprio_w)
  );

  ivag_addr_calc #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_SPACED(NUM_SPACED),
    .NUM_TBL(NUM_TBL), .VEC_W(VEC_W), .FIXED_OFF(FIXED_OFF)
  ) u_calc (
    .mode(mode), .vec(req_vec), .base(base_w), .code(code_w), .off(lk_off),
    .addr(calc_addr), .err(calc_err)
  );

  ivag_set_sel #(.PRIO_W(PRIO_W), .SET_W(SET_W)) u_set (
    .mode(mode), .prio(req_prio), .map(map_w), .sprio(sprio_w), .set(calc_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr <= '0;
      out_set  <= '0;
      out_err  <= 1'b0;
    end else if (req) begin
      out_addr <= calc_addr;
      out_set  <= calc_set;
      out_err  <= calc_err;
    end
  end

  assert_valid_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> out_valid);
  assert_no_valid_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !out_valid);
  assert_err_gives_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> out_addr == $past(base_w));
  assert_table_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err && $past(mode_tbl)) |->
      (((out_addr - $past(base_w)) >> OFF_W) == '0));
  assert_spaced_above_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err && !$past(mode_tbl)) |->
      ((out_addr - $past(base_w)) >= ADDR_W'(FIXED_OFF)));
  assert_spaced_set_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(mode_tbl)) |-> out_set <= SET_W'(1));
endmodule

// File: tb/test_irq_vector_gen.sv
module test_irq_vector_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_tbl, cfg_we, req;
  logic [8:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, out_addr;
  logic [7:0]  req_vec;
  logic [2:0]  req_prio;
  logic        out_valid, out_err;
  logic [3:0]  out_set;

  always #4 clk = ~clk;

  irq_vector_gen i_irq_vector_gen (
    .clk(clk), .rst_n(rst_n), .mode_tbl(mode_tbl), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req(req), .req_vec(req_vec), .req_prio(req_prio), .out_valid(out_valid),
    .out_addr(out_addr), .out_set(out_set), .out_err(out_err)
  );

  typedef struct {
    logic [31:0] a;
    logic [3:0]  s;
    logic        e;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [31:0] m_base  = 32'h9D00_0000;
  logic [2:0]  m_code  = 3'd3;
  logic [31:0] m_map   = 32'h7654_3210;
  logic [2:0]  m_sprio = 3'd7;
  logic [17:0] m_tbl [191];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stride(logic [2:0] c);
    return (c == 3'd0) ? 32'd0 : (32'd4 << c);
  endfunction

  task automatic send(logic [7:0] v, logic [2:0] p, string tag);
    exp_t x;
    bit   inr;
    @(negedge clk);
    cfg_we = 1'b0; req = 1'b1; req_vec = v; req_prio = p;
    x.tag = tag;
    if (!mode_tbl) begin
      inr = v < 8'd64;
      x.a = inr ? m_base + stride(m_code) * {24'd0, v} + 32'h200 : m_base;
      x.s = (p == m_sprio) ? 4'd1 : 4'd0;
    end else begin
      inr = v < 8'd191;
      x.a = inr ? m_base + {14'd0, m_tbl[v]} : m_base;
      x.s = m_map[int'(p)*4 +: 4];
    end
    x.e = !inr;
    sb.push_back(x);
  endtask

  task automatic wr(logic [8:0] ad, logic [31:0] d, logic [31:0] old, string tag);
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    #1 chk(tag, cfg_rdata, old);
    case (ad)
      9'h100: m_base  = d;
      9'h101: m_code  = d[2:0];
      9'h102: m_map   = d;
      9'h103: m_sprio = d[2:0];
      default: if (ad < 9'd191) m_tbl[ad] = d[17:0];
    endcase
  endtask

  task automatic rd(logic [8:0] ad, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0; cfg_addr = ad;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0;
    for (int k = 1; k < n; k++) @(negedge clk);
  endtask

  task automatic setmode(logic m);
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0; mode_tbl = m;
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done && out_valid === 1'b1) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R9: unexpected valid, actual 1 expected 0");
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk({x.tag, " addr"}, out_addr, x.a);
        chk({x.tag, " set"}, {28'd0, out_set}, {28'd0, x.s});
        chk({x.tag, " err"}, {31'd0, out_err}, {31'd0, x.e});
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 191; i++) m_tbl[i] = '0;
    rst_n = 1'b0; mode_tbl = 1'b0; cfg_we = 1'b0; req = 1'b0;
    cfg_addr = '0; cfg_wdata = '0; req_vec = '0; req_prio = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    rd(9'h100, 32'h9D00_0000, "R1 base");
    rd(9'h101, 32'd3, "R1 stride code");
    rd(9'h102, 32'h7654_3210, "R1 map");
    rd(9'h103, 32'd7, "R1 shadow prio");
    rd(9'd5, 32'd0, "R1 table entry");
    rd(9'h1F0, 32'd0, "R8 unmapped read");
    chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);

    send(8'd0, 3'd7, "R2 R7 vec0");
    send(8'd5, 3'd3, "R2 vec5");
    send(8'd63, 3'd0, "R2 vec63");
    wr(9'h101, 32'd7, 32'd3, "R8 code old");
    send(8'd10, 3'd1, "R2 stride512");
    wr(9'h101, 32'd1, 32'd7, "R8 code old");
    send(8'd3, 3'd2, "R2 stride8");
    wr(9'h101, 32'd0, 32'd1, "R8 code old");
    send(8'd0, 3'd2, "R3 zero stride v0");
    send(8'd40, 3'd2, "R3 zero stride v40");
    send(8'd64, 3'd7, "R5 spaced 64");
    send(8'd200, 3'd1, "R5 spaced 200");
    wr(9'h103, 32'd3, 32'd7, "R8 sprio old");
    send(8'd1, 3'd3, "R7 match");
    send(8'd1, 3'd7, "R7 nomatch");
    idle(3);
    chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R9 queue drained", sb.size(), 0);

    wr(9'h100, 32'h8000_1000, 32'h9D00_0000, "R8 base old");
    setmode(1'b1);
    wr(9'd0, 32'h0000_0123, 32'd0, "R8 tbl0 old");
    wr(9'd100, 32'h0007_FFFF, 32'd0, "R8 tbl100 old");
    rd(9'd100, 32'h0003_FFFF, "R4 truncation");
    wr(9'd100, 32'h0000_0010, 32'h0003_FFFF, "R8 tbl100 previous");
    wr(9'd190, 32'h0002_ABCD, 32'd0, "R8 tbl190 old");
    send(8'd0, 3'd0, "R4 R6 tbl0");
    send(8'd100, 3'd5, "R4 R6 tbl100");
    send(8'd190, 3'd7, "R4 tbl190");
    send(8'd50, 3'd2, "R4 tbl50 zero");
    wr(9'h102, 32'h0FED_CBA9, 32'h7654_3210, "R8 map old");
    send(8'd190, 3'd0, "R6 map p0");
    send(8'd100, 3'd7, "R6 map p7");
    send(8'd191, 3'd4, "R5 table 191");
    send(8'd255, 3'd4, "R5 table 255");
    idle(3);
    chk("R9 final idle", {31'd0, out_valid}, 32'd0);
    chk("R9 final queue", sb.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule